// File: doc/BRIEF.md
# Carry-Free Fast Address Predictor

This unit sits in front of a data cache and turns a base register value plus an offset or index into the address fields the cache needs. The cache row has to be selected at the very start of the access, so the set index is predicted with a bitwise OR of the base and offset index bits. An OR has no carry chain and is ready at once. In parallel, a full adder forms the true effective address, and from it the block offset and the tag, which the cache only uses late in the access.

A carry check reports whether the OR-formed index can be trusted. The prediction fails if a carry comes up out of the block-offset bits, or if the base and the offset both have a 1 in the same index bit. Loads that add two registers are never speculated. For them the unit hands out the true index from the sum and marks the access as non-speculative. Each accepted request produces one registered result one cycle later, under a ready/valid handshake on the input side with a stall input on the output side. The cache geometry is set by parameters.

Top module: `fast_set_predictor`

## Requirements
With the default geometry (32-bit address, 32-byte blocks, 16 KiB, one way), the block offset is address bits [4:0], the set index is bits [13:5] and the tag is bits [31:14].
- R1: For a speculative request (`in_reg_mode`=0), `out_set_pred` equals the OR of `in_base[13:5]` and `in_ofs[13:5]`.
- R2: `out_ea` equals `in_base + in_ofs` modulo 2^32, `out_blk_ofs` equals its bits [4:0] and `out_tag` equals its bits [31:14].
- R3: `out_pred_ok` is 1 exactly when the request is speculative, `in_base[4:0] + in_ofs[4:0]` is below 32, and no index bit in [13:5] is 1 in both operands. Whenever it is 1, `out_set_pred` equals `out_ea[13:5]`.
- R4: A speculative request whose offset has zero index bits, and whose low five bits add without carry, is reported with `out_pred_ok`=1.
- R5: For a register-plus-register request (`in_reg_mode`=1), `out_spec`=0, `out_pred_ok`=0 and `out_set_pred` equals `out_ea[13:5]`.
- R6: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid`=1 after that same edge.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output holds its value. In any other state `in_ready` is 1.
- R8: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R9: If both operands have all index bits set and the low bits carry, the OR index happens to equal the true index, but `out_pred_ok` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_base | input | ADDR_W | Base register value |
| in_ofs | input | ADDR_W | Immediate offset or index register value |
| in_reg_mode | input | 1 | 1 = register-plus-register, not speculated |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_set_pred | output | IDX_W | Set index to start the row read with |
| out_blk_ofs | output | OFS_W | True block offset |
| out_tag | output | TAG_W | True tag |
| out_ea | output | ADDR_W | Full effective address |
| out_spec | output | 1 | 1 when the index was predicted |
| out_pred_ok | output | 1 | Predicted index is trustworthy |

## Verification
The assertions check four things on every cycle. A trusted prediction always matches the index of the true sum. A register-plus-register result is never marked trustworthy. Each accepted request produces an output on the next edge. Results are held while the consumer stalls. Two behaviours only the bench's scenarios can show. One is the exact carry rule: that small offsets succeed and that the all-ones corner is still rejected despite matching indices. The other is that the OR value and the adder fields are right for each mix of offset sizes, signs and stall patterns.

// File: rtl/fast_set_predictor.sv
module fast_set_predictor #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int WAYS        = 1,
  localparam int OFS_W  = $clog2(BLOCK_BYTES),
  localparam int SETS   = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_ofs,
  input  logic              in_reg_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_set_pred,
  output logic [OFS_W-1:0]  out_blk_ofs,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ADDR_W-1:0] out_ea,
  output logic              out_spec,
  output logic              out_pred_ok
);
  localparam int IDX_LO = OFS_W;
  localparam int IDX_HI = OFS_W + IDX_W - 1;

  logic [ADDR_W-1:0] ea_sum;
  logic [IDX_W-1:0]  idx_or;
  logic              carry_in_idx;
  logic              carry_gen_idx;
  logic              spec_ok;
  logic              take;

  assign ea_sum        = in_base + in_ofs;
  assign idx_or        = in_base[IDX_HI:IDX_LO] | in_ofs[IDX_HI:IDX_LO];
  assign carry_in_idx  = ea_sum[IDX_LO] ^ in_base[IDX_LO] ^ in_ofs[IDX_LO];
  assign carry_gen_idx = |(in_base[IDX_HI:IDX_LO] & in_ofs[IDX_HI:IDX_LO]);
  assign spec_ok       = !in_reg_mode && !carry_in_idx && !carry_gen_idx;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_set_pred <= '0;
      out_blk_ofs  <= '0;
      out_tag      <= '0;
      out_ea       <= '0;
      out_spec     <= 1'b0;
      out_pred_ok  <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_set_pred <= in_reg_mode ? ea_sum[IDX_HI:IDX_LO] : idx_or;
      out_blk_ofs  <= ea_sum[OFS_W-1:0];
      out_tag      <= ea_sum[ADDR_W-1:IDX_HI+1];
      out_ea       <= ea_sum;
      out_spec     <= !in_reg_mode;
      out_pred_ok  <= spec_ok;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/fast_set_predictor_chk.sv
module fast_set_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  parameter int IDX_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_set_pred,
  input logic [ADDR_W-1:0] out_ea,
  input logic              out_spec,
  input logic              out_pred_ok
);
  assert_trusted_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pred_ok |-> out_set_pred == out_ea[OFS_W+IDX_W-1:OFS_W]);

  assert_nonspec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_spec |-> !out_pred_ok && out_set_pred == out_ea[OFS_W+IDX_W-1:OFS_W]);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea) && $stable(out_set_pred)
                                && $stable(out_pred_ok) && $stable(out_spec));

  assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind fast_set_predictor fast_set_predictor_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_set_pred(out_set_pred),
  .out_ea(out_ea), .out_spec(out_spec), .out_pred_ok(out_pred_ok)
);

// File: tb/test_fast_set_predictor.sv
module test_fast_set_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_base = '0;
  logic [31:0] in_ofs = '0;
  logic        in_reg_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [8:0]  out_set_pred;
  logic [4:0]  out_blk_ofs;
  logic [17:0] out_tag;
  logic [31:0] out_ea;
  logic        out_spec;
  logic        out_pred_ok;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fast_set_predictor i_fast_set_predictor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_ofs(in_ofs), .in_reg_mode(in_reg_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_set_pred(out_set_pred),
    .out_blk_ofs(out_blk_ofs), .out_tag(out_tag), .out_ea(out_ea),
    .out_spec(out_spec), .out_pred_ok(out_pred_ok)
  );

  // behavioural reference
  bit        m_valid = 1'b0;
  bit [31:0] m_ea, m_idx;
  bit        m_spec, m_ok;

  function automatic bit ref_ok(bit [31:0] b, bit [31:0] o, bit rr);
    int lo = int'(b % 32) + int'(o % 32);
    int bi = int'((b / 32) % 512);
    int oi = int'((o / 32) % 512);
    return !rr && lo < 32 && ((bi & oi) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_ea    <= in_base + in_ofs;
      m_spec  <= !in_reg_mode;
      m_ok    <= ref_ok(in_base, in_ofs, in_reg_mode);
      m_idx   <= in_reg_mode ? ((in_base + in_ofs) / 32) % 512
                             : ((in_base / 32) % 512) | ((in_ofs / 32) % 512);
    end else if (out_ready) m_valid <= 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk("R6 out_valid", 32'(out_valid), 32'(m_valid));
    chk("R7 in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
    if (m_valid) begin
      chk("R2 out_ea", out_ea, m_ea);
      chk("R2 out_blk_ofs", 32'(out_blk_ofs), m_ea % 32);
      chk("R2 out_tag", 32'(out_tag), m_ea / 16384);
      chk(m_spec ? "R1 out_set_pred" : "R5 out_set_pred", 32'(out_set_pred), m_idx);
      chk("R5 out_spec", 32'(out_spec), 32'(m_spec));
      chk("R3 out_pred_ok", 32'(out_pred_ok), 32'(m_ok));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic one_shot(bit [31:0] b, bit [31:0] o, bit rr);
    @(negedge clk); compare();
    in_valid = 1'b1; in_base = b; in_ofs = o; in_reg_mode = rr; out_ready = 1'b1;
    @(negedge clk); compare();
    in_valid = 1'b0;
  endtask

  always @(posedge clk) cycles++;

  initial begin
    while (cycles < 200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    summary();
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R8 out_valid in reset", 32'(out_valid), 32'h0);
      chk("R8 in_ready in reset", 32'(in_ready), 32'h1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after reset", 32'(out_valid), 32'h0);

    one_shot(32'h1234_5660, 32'h0000_0010, 1'b0);
    chk("R4 small offset trusted", 32'(out_pred_ok), 32'h1);
    chk("R4 index", 32'(out_set_pred), 32'h0B3);
    one_shot(32'h1234_567F, 32'h0000_0001, 1'b0);
    chk("R3 low carry rejects", 32'(out_pred_ok), 32'h0);
    one_shot(32'h0000_3FFF, 32'h0000_3FE1, 1'b0);
    chk("R9 all-ones corner rejected", 32'(out_pred_ok), 32'h0);
    chk("R9 index equal anyway", 32'(out_set_pred), 32'h1FF);
    one_shot(32'h1000_0040, 32'h0000_0040, 1'b0);
    chk("R3 generated carry rejects", 32'(out_pred_ok), 32'h0);
    chk("R1 OR index", 32'(out_set_pred), 32'h002);
    one_shot(32'h1000_0040, 32'h0000_0040, 1'b1);
    chk("R5 reg-reg not trusted", 32'(out_pred_ok), 32'h0);
    chk("R5 reg-reg true index", 32'(out_set_pred), 32'h004);
    chk("R5 reg-reg not speculative", 32'(out_spec), 32'h0);

    @(negedge clk); compare();
    in_valid = 1'b1; in_base = 32'hAAAA_0000; in_ofs = 32'h8; in_reg_mode = 1'b0; out_ready = 1'b0;
    @(negedge clk); compare();
    in_base = 32'h5555_0000;
    @(negedge clk); compare();
    chk("R7 held ea under stall", out_ea, 32'hAAAA_0008);
    chk("R7 ready low under stall", 32'(in_ready), 32'h0);
    in_valid = 1'b0; out_ready = 1'b1;

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); compare();
      in_valid    = ($urandom % 4) != 0;
      out_ready   = ($urandom % 5) != 0;
      in_reg_mode = ($urandom % 6) == 0;
      in_base     = $urandom;
      case ($urandom % 4)
        0: in_ofs = $urandom % 32;
        1: in_ofs = $urandom % 1024;
        2: in_ofs = -($urandom % 64);
        default: in_ofs = $urandom;
      endcase
      if ($urandom % 3 == 0) in_base[13:0] = '0;
    end
    @(negedge clk); compare();
    summary();
  end
endmodule